// File: doc/BRIEF.md
# Fetch Address Selector with Static Branch Prediction

This block decides, every clock cycle, which instruction address the fetch stage of a five-stage in-order pipeline issues next. It keeps the current fetch address in a register and picks the next one from five sources. The sources are the sequential successor, a branch target, a fixed interrupt vector, a saved interruption return address and the reset pointer. Every branch has one architectural delay slot. When a branch reaches the execute stage, the delay slot address is already being fetched. The address chosen in that cycle therefore belongs to the instruction after the delay slot, and it uses the target from the execute-stage adder.

Conditional branches use a static direction rule. A backward displacement (sign bit set) is guessed taken, and a forward one is guessed not taken. The real condition outcome is captured in the execute cycle and compared in the next cycle. If the guess was wrong, the block raises `flush` for the one instruction fetched on the wrong path and redirects fetch to the correct address. That address is the target, or the delay slot address plus the step.

A two-state machine tracks the pending comparison. The states are `ST_SEQ` (no outcome pending) and `ST_CHECK` (a conditional branch awaits comparison). The transition `accept_cond` moves `ST_SEQ` to `ST_CHECK`, and also keeps the machine in `ST_CHECK`, when an unstalled conditional branch sits in execute with no correction due and no interrupt or return request. The transition `resolve` moves `ST_CHECK` back to `ST_SEQ` on any other unstalled cycle. A stall holds every register.

Top module: `fetch_addr_sel`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` equals the reset pointer `RESET_VEC` and `flush` is low. The reset pointer is the first address issued after release.
- R2: With no request, no branch and no correction, each unstalled clock edge advances `fetch_addr` by `STEP` (4), wrapping modulo 2^ADDR_W.
- R3: An unconditional branch (`ex_br_valid`=1, `ex_br_cond`=0) makes the next `fetch_addr` equal `ex_target`. The delay slot already being fetched is not flushed.
- R4: A conditional branch with `ex_disp_neg`=1 is predicted taken, and the next `fetch_addr` equals `ex_target`.
- R5: A conditional branch with `ex_disp_neg`=0 is predicted not taken, and the next `fetch_addr` is the current one plus `STEP`.
- R6: When the prediction matches `ex_cond_taken`, `flush` stays low and fetch continues sequentially from the predicted address.
- R7: When the prediction is wrong, `flush` is high for exactly the one cycle after the branch's execute cycle. At the end of that cycle `fetch_addr` becomes `ex_target` if the branch was taken, or the delay slot address plus `STEP` if it was not.
- R8: `irq_req` has the highest priority after reset. The next `fetch_addr` equals `IRQ_VEC`, overriding return, correction, branch and sequential sources, and any pending comparison is dropped.
- R9: `rfi_req` without `irq_req` makes the next `fetch_addr` equal `rfi_addr`, overriding correction, branch and sequential sources.
- R10: While `stall` is high, `fetch_addr` and the pending comparison hold and `flush` is low. A pending correction takes effect after the stall ends.
- R11: Targets and return addresses are word aligned by forcing their low log2(STEP) bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze fetch address and pending state |
| irq_req | input | 1 | Interrupt request, selects the interrupt vector |
| rfi_req | input | 1 | Return from interruption, selects `rfi_addr` |
| rfi_addr | input | ADDR_W | Saved interruption return address |
| ex_br_valid | input | 1 | A branch is in the execute stage |
| ex_br_cond | input | 1 | The branch in execute is conditional |
| ex_disp_neg | input | 1 | Sign of the branch displacement (1 = backward) |
| ex_cond_taken | input | 1 | Evaluated condition outcome of the branch in execute |
| ex_target | input | ADDR_W | Target from the execute-stage adder |
| fetch_addr | output | ADDR_W | Current instruction fetch address |
| flush | output | 1 | Discard the instruction fetched on the wrong path |

## Verification
The bench builds the block with `RESET_VEC` set to 32'hFFFF_FFF8 and `IRQ_VEC` set to 32'h0000_0800, with `ADDR_W` 32 and `STEP` 4. The reset pointer sits two steps below the top of the address space, so the sequential wrap to zero is reached right after reset. A misaligned target value exposes the low-bit masking. Priority collisions are staged against a pending correction, including a stall that holds a correction across several cycles.

// File: rtl/fas_pkg.sv
package fas_pkg;

    typedef enum logic [0:0] {
        ST_SEQ   = 1'b0,
        ST_CHECK = 1'b1
    } fas_state_t;

    typedef enum logic [2:0] {
        SRC_SEQ  = 3'd0,
        SRC_PRED = 3'd1,
        SRC_FIX  = 3'd2,
        SRC_RFI  = 3'd3,
        SRC_IRQ  = 3'd4
    } fas_src_t;

endpackage

// File: rtl/fas_predict.sv
// Static direction guess: unconditional always taken, conditional taken
// only when the displacement points backward.
module fas_predict (
    input  logic is_cond,
    input  logic disp_neg,
    output logic guess_taken
);
    always_comb begin
        guess_taken = !is_cond || disp_neg;
    end
endmodule

// File: rtl/fas_ctrl.sv
module fas_ctrl
    import fas_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall,
    input  logic       irq_req,
    input  logic       rfi_req,
    input  logic       ex_br_valid,
    input  logic       ex_br_cond,
    input  logic       guess_taken,
    input  logic       ex_cond_taken,
    output fas_src_t   src_sel,
    output logic       load_fix,
    output logic       flush
);
    fas_state_t state_q, state_n;
    logic       wrong_q, wrong_n;
    logic       fix_due;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            wrong_q <= 1'b0;
        end else if (!stall) begin
            state_q <= state_n;
            wrong_q <= wrong_n;
        end
    end

    // Next state and outputs
    always_comb begin
        fix_due  = (state_q == ST_CHECK) && wrong_q;
        state_n  = ST_SEQ;
        wrong_n  = 1'b0;
        load_fix = 1'b0;
        flush    = fix_due && !stall;
        src_sel  = SRC_SEQ;

        if (irq_req) begin
            src_sel = SRC_IRQ;
        end else if (rfi_req) begin
            src_sel = SRC_RFI;
        end else if (fix_due) begin
            src_sel = SRC_FIX;
        end else if (ex_br_valid && guess_taken) begin
            src_sel = SRC_PRED;
        end

        unique case (state_q)
            ST_SEQ, ST_CHECK: begin
                // accept_cond / resolve
                if (!irq_req && !rfi_req && !fix_due && ex_br_valid && ex_br_cond) begin
                    state_n  = ST_CHECK;
                    wrong_n  = (guess_taken != ex_cond_taken);
                    load_fix = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/fas_addr_path.sv
module fas_addr_path
    import fas_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              STEP      = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0,
    parameter logic [ADDR_W-1:0] IRQ_VEC   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  fas_src_t          src_sel,
    input  logic              load_fix,
    input  logic              ex_cond_taken,
    input  logic [ADDR_W-1:0] ex_target,
    input  logic [ADDR_W-1:0] rfi_addr,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam logic [ADDR_W-1:0] STEP_V     = ADDR_W'(STEP);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(STEP_V - ADDR_W'(1));

    logic [ADDR_W-1:0] pc_q, fix_q, pc_n, seq_addr, tgt_al, rfi_al;

    always_comb begin
        seq_addr = pc_q + STEP_V;
        tgt_al   = ex_target & ALIGN_MASK;
        rfi_al   = rfi_addr & ALIGN_MASK;
        pc_n     = seq_addr;
        unique case (src_sel)
            SRC_IRQ:  pc_n = IRQ_VEC;
            SRC_RFI:  pc_n = rfi_al;
            SRC_FIX:  pc_n = fix_q;
            SRC_PRED: pc_n = tgt_al;
            SRC_SEQ:  pc_n = seq_addr;
            default:  pc_n = seq_addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= RESET_VEC;
            fix_q <= RESET_VEC;
        end else if (!stall) begin
            pc_q <= pc_n;
            if (load_fix) begin
                fix_q <= ex_cond_taken ? tgt_al : seq_addr;
            end
        end
    end

    assign fetch_addr = pc_q;
endmodule

// File: rtl/fetch_addr_sel.sv
module fetch_addr_sel
    import fas_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              STEP      = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0,
    parameter logic [ADDR_W-1:0] IRQ_VEC   = ADDR_W'(32'h0000_0800)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              irq_req,
    input  logic              rfi_req,
    input  logic [ADDR_W-1:0] rfi_addr,
    input  logic              ex_br_valid,
    input  logic              ex_br_cond,
    input  logic              ex_disp_neg,
    input  logic              ex_cond_taken,
    input  logic [ADDR_W-1:0] ex_target,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              flush
);
    fas_src_t src_sel;
    logic     guess_taken;
    logic     load_fix;

    fas_predict u_pred (
        .is_cond     (ex_br_cond),
        .disp_neg    (ex_disp_neg),
        .guess_taken (guess_taken)
    );

    fas_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall         (stall),
        .irq_req       (irq_req),
        .rfi_req       (rfi_req),
        .ex_br_valid   (ex_br_valid),
        .ex_br_cond    (ex_br_cond),
        .guess_taken   (guess_taken),
        .ex_cond_taken (ex_cond_taken),
        .src_sel       (src_sel),
        .load_fix      (load_fix),
        .flush         (flush)
    );

    fas_addr_path #(
        .ADDR_W    (ADDR_W),
        .STEP      (STEP),
        .RESET_VEC (RESET_VEC),
        .IRQ_VEC   (IRQ_VEC)
    ) u_path (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall         (stall),
        .src_sel       (src_sel),
        .load_fix      (load_fix),
        .ex_cond_taken (ex_cond_taken),
        .ex_target     (ex_target),
        .rfi_addr      (rfi_addr),
        .fetch_addr    (fetch_addr)
    );
endmodule

// File: rtl/fas_checker.sv
module fas_checker #(
    parameter int              ADDR_W    = 32,
    parameter int              STEP      = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0,
    parameter logic [ADDR_W-1:0] IRQ_VEC   = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              irq_req,
    input logic              rfi_req,
    input logic [ADDR_W-1:0] rfi_addr,
    input logic              ex_br_valid,
    input logic              ex_br_cond,
    input logic              ex_disp_neg,
    input logic [ADDR_W-1:0] ex_target,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              flush
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
    localparam logic [ADDR_W-1:0] MASK   = ~(STEP_V - ADDR_W'(1));

    logic quiet;
    assign quiet = !stall && !irq_req && !rfi_req && !flush;

    // R1
    a_r1_reset_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> fetch_addr == RESET_VEC);

    // R2
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !ex_br_valid) |=> fetch_addr == $past(fetch_addr) + STEP_V);

    // R3, R4, R11
    a_r4_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && ex_br_valid && (!ex_br_cond || ex_disp_neg))
            |=> fetch_addr == ($past(ex_target) & MASK));

    // R5
    a_r5_forward_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && ex_br_valid && ex_br_cond && !ex_disp_neg)
            |=> fetch_addr == $past(fetch_addr) + STEP_V);

    // R8
    a_r8_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !stall) |=> fetch_addr == IRQ_VEC);

    // R9
    a_r9_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_req && !irq_req && !stall) |=> fetch_addr == ($past(rfi_addr) & MASK));

    // R10
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(fetch_addr));
endmodule

bind fetch_addr_sel fas_checker #(
    .ADDR_W    (ADDR_W),
    .STEP      (STEP),
    .RESET_VEC (RESET_VEC),
    .IRQ_VEC   (IRQ_VEC)
) u_fas_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .irq_req     (irq_req),
    .rfi_req     (rfi_req),
    .rfi_addr    (rfi_addr),
    .ex_br_valid (ex_br_valid),
    .ex_br_cond  (ex_br_cond),
    .ex_disp_neg (ex_disp_neg),
    .ex_target   (ex_target),
    .fetch_addr  (fetch_addr),
    .flush       (flush)
);

// File: tb/fetch_addr_sel_test.sv
`timescale 1ns/1ps
module fetch_addr_sel_test;
    localparam logic [31:0] RV = 32'hFFFF_FFF8;
    localparam logic [31:0] IV = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall, irq_req, rfi_req;
    logic [31:0] rfi_addr;
    logic        ex_br_valid, ex_br_cond, ex_disp_neg, ex_cond_taken;
    logic [31:0] ex_target;
    logic [31:0] fetch_addr;
    logic        flush;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fetch_addr_sel #(
        .ADDR_W(32), .STEP(4), .RESET_VEC(RV), .IRQ_VEC(IV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .irq_req(irq_req),
        .rfi_req(rfi_req), .rfi_addr(rfi_addr), .ex_br_valid(ex_br_valid),
        .ex_br_cond(ex_br_cond), .ex_disp_neg(ex_disp_neg),
        .ex_cond_taken(ex_cond_taken), .ex_target(ex_target),
        .fetch_addr(fetch_addr), .flush(flush)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        stall = 0; irq_req = 0; rfi_req = 0; rfi_addr = '0;
        ex_br_valid = 0; ex_br_cond = 0; ex_disp_neg = 0;
        ex_cond_taken = 0; ex_target = '0;
    endtask

    task automatic branch(input logic cond, input logic neg, input logic tk, input logic [31:0] t);
        ex_br_valid = 1; ex_br_cond = cond; ex_disp_neg = neg;
        ex_cond_taken = tk; ex_target = t;
    endtask

    task automatic t_reset();
        idle();
        rst_n = 0;
        repeat (3) tick();
        chk("R1 reset addr", fetch_addr, RV);
        chk("R1 reset flush", {31'd0, flush}, 32'd0);
        rst_n = 1;
        tick();
        chk("R2 step", fetch_addr, 32'hFFFF_FFFC);
        tick();
        chk("R2 wrap", fetch_addr, 32'h0000_0000);
    endtask

    task automatic t_uncond();
        logic [31:0] f;
        f = fetch_addr;
        branch(0, 0, 0, 32'h0000_1003);
        tick(); idle();
        chk("R3 R11 uncond target aligned", fetch_addr, 32'h0000_1000);
        chk("R3 delay slot kept", {31'd0, flush}, 32'd0);
        tick();
        chk("R2 after branch", fetch_addr, 32'h0000_1004);
        if (f == 32'h0) chk("R2 base", f, 32'h0);
    endtask

    task automatic t_back_hit();
        branch(1, 1, 1, 32'h0000_2000);
        tick(); idle();
        chk("R4 backward taken", fetch_addr, 32'h0000_2000);
        chk("R6 no flush", {31'd0, flush}, 32'd0);
        tick();
        chk("R6 continue", fetch_addr, 32'h0000_2004);
    endtask

    task automatic t_back_miss();
        logic [31:0] f;
        f = fetch_addr;
        branch(1, 1, 0, 32'h0000_3000);
        tick(); idle();
        chk("R4 backward guess", fetch_addr, 32'h0000_3000);
        chk("R7 flush raised", {31'd0, flush}, 32'd1);
        tick();
        chk("R7 fall-through", fetch_addr, f + 32'd4);
        chk("R7 flush one cycle", {31'd0, flush}, 32'd0);
    endtask

    task automatic t_fwd_miss();
        logic [31:0] f;
        f = fetch_addr;
        branch(1, 0, 1, 32'h0000_4000);
        tick(); idle();
        chk("R5 forward guess", fetch_addr, f + 32'd4);
        chk("R7 flush raised", {31'd0, flush}, 32'd1);
        tick();
        chk("R7 taken target", fetch_addr, 32'h0000_4000);
        chk("R7 flush one cycle", {31'd0, flush}, 32'd0);
    endtask

    task automatic t_fwd_hit();
        logic [31:0] f;
        f = fetch_addr;
        branch(1, 0, 0, 32'h0000_4800);
        tick(); idle();
        chk("R5 forward not taken", fetch_addr, f + 32'd4);
        chk("R6 no flush", {31'd0, flush}, 32'd0);
        tick();
        chk("R6 continue", fetch_addr, f + 32'd8);
    endtask

    task automatic t_irq();
        branch(0, 0, 0, 32'h0000_6000);
        rfi_req = 1; rfi_addr = 32'h0000_5550; irq_req = 1;
        tick(); idle();
        chk("R8 irq wins", fetch_addr, IV);
        // irq over a pending correction
        branch(1, 1, 0, 32'h0000_3000);
        tick(); idle();
        irq_req = 1;
        tick(); idle();
        chk("R8 irq over fix", fetch_addr, IV);
        chk("R8 check dropped", {31'd0, flush}, 32'd0);
    endtask

    task automatic t_rfi();
        branch(0, 0, 0, 32'h0000_6000);
        rfi_req = 1; rfi_addr = 32'h0000_5552;
        tick(); idle();
        chk("R9 R11 return addr", fetch_addr, 32'h0000_5550);
        branch(1, 0, 1, 32'h0000_4000);
        tick(); idle();
        rfi_req = 1; rfi_addr = 32'h0000_7000;
        tick(); idle();
        chk("R9 rfi over fix", fetch_addr, 32'h0000_7000);
    endtask

    task automatic t_stall();
        logic [31:0] f;
        f = fetch_addr;
        stall = 1; irq_req = 1;
        tick();
        chk("R10 hold", fetch_addr, f);
        tick();
        chk("R10 hold again", fetch_addr, f);
        idle();
        tick();
        chk("R10 resume", fetch_addr, f + 32'd4);
        // stall across a pending correction
        f = fetch_addr;
        branch(1, 1, 0, 32'h0000_3100);
        tick(); idle();
        stall = 1;
        #1;
        chk("R10 no flush in stall", {31'd0, flush}, 32'd0);
        tick();
        chk("R10 hold wrong path", fetch_addr, 32'h0000_3100);
        chk("R10 no flush held", {31'd0, flush}, 32'd0);
        stall = 0;
        #1;
        chk("R10 R7 flush after stall", {31'd0, flush}, 32'd1);
        tick();
        chk("R10 R7 fix applied", fetch_addr, f + 32'd4);
    endtask

    initial begin
        t_reset();
        t_uncond();
        t_back_hit();
        t_back_miss();
        t_fwd_miss();
        t_fwd_hit();
        t_irq();
        t_rfi();
        t_stall();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule